// File: doc/BRIEF.md
# Reference Clock Frequency Meter

This block measures the rate of a free-running clock that arrives from an external microcontroller and is not related to the system clock. The incoming clock is brought into the system clock domain through a flop chain. Each of its rising edges becomes a one-cycle pulse. The pulses are counted over a gate of fixed length, timed by the system clock. When a gate closes, the total is copied into a read-only result register in one step, and the next gate begins in the following cycle.

The gate length is set in system clock cycles. By default it equals half the system clock frequency, so each gate lasts half a second. The register therefore holds half the input frequency and is refreshed twice per second. A nominal 100 kHz input reads about 50000.

Software reads the result through a plain register read port. The result sits at byte offset 0x0A, and a read returns one cycle after it is requested. The read port has no back-pressure: a request is accepted in every cycle, and its answer is marked valid for exactly one cycle with no stall.

Top module: `freq_meter`

## Requirements
- R1: The external clock passes through SYNC_STAGES flops, with a default of 2. Each of its rising edges produces exactly one count pulse in the system clock domain.
- R2: A gate closes every GATE_CYCLES system clock cycles. The first gate closes GATE_CYCLES cycles after reset is released, and the gates follow back to back with no gap.
- R3: While the input is stable, the result equals the number of input rising edges seen in one gate. With the default gate this is half the input frequency in Hz.
- R4: The count saturates at 2^CNT_W-1 and does not wrap. With the default CNT_W of 16 this limit is 0xFFFF.
- R5: After reset the result reads zero until the first gate closes.
- R6: The result register changes only on the clock edge that closes a gate. It always holds the complete count of one gate and keeps that value for the whole of the following gate.
- R7: A request with rd_en=1 and rd_addr=0x0A gives rd_valid=1 and rd_data equal to the result on the next cycle. A CNT_W-bit result is zero-extended to REG_W bits.
- R8: A request with rd_en=1 at any other address gives rd_valid=1 and rd_data=0 on the next cycle.
- R9: When rd_en=0, the next cycle shows rd_valid=0 and rd_data=0.
- R10: If the input clock shows no rising edge for a whole gate, that gate's result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_clk | input | 1 | External reference clock, asynchronous to clk |
| rd_en | input | 1 | Read request strobe |
| rd_addr | input | ADDR_W | Byte offset of the register to read |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | REG_W | Read data |

## Verification
A fault in the edge counter or in the gate timer appears at the ports at the first gate that closes afterwards. The fault shows up as a wrong count or as a refresh on the wrong cycle, and it is visible on the read one cycle after that closing edge. A result register that is not held, or that is loaded part of the way through a gate, shows up when the value is read back in the middle of the gate. A fault in the read path appears on the very next response.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;

  // Unsigned add of a single pulse that stops at all-ones.
  function automatic logic [31:0] sat_inc(input logic [31:0] val,
                                          input logic        inc,
                                          input logic [31:0] top);
    if (inc && (val != top)) return val + 32'd1;
    return val;
  endfunction

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fm_gate.sv
module fm_gate #(
  parameter int GATE_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic gate_end
);
  localparam int GW = $clog2(GATE_CYCLES);
  localparam logic [GW-1:0] LAST = GW'(GATE_CYCLES - 1);

  logic [GW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (rst)           tick_q <= '0;
    else if (gate_end) tick_q <= '0;
    else               tick_q <= tick_q + 1'b1;
  end

  assign gate_end = (tick_q == LAST);
endmodule

// File: rtl/fm_counter.sv
module fm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse,
  input  logic             gate_end,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] total
);
  import freq_meter_pkg::*;
  localparam logic [31:0] TOP = 32'((64'd1 << CNT_W) - 64'd1);

  // Total including a pulse that lands in the closing cycle.
  assign total = CNT_W'(sat_inc(32'(cnt_q), pulse, TOP));

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (gate_end) cnt_q <= '0;
    else               cnt_q <= total;
  end
endmodule

// File: rtl/fm_regport.sv
module fm_regport #(
  parameter int          CNT_W      = 16,
  parameter int          REG_W      = 16,
  parameter int          ADDR_W     = 8,
  parameter int unsigned REG_OFFSET = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  result_q,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFFSET);

  always_ff @(posedge clk) begin
    if (rst)       result_q <= '0;
    else if (load) result_q <= load_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en && (rd_addr == OFF)) rd_data <= REG_W'(result_q);
      else                           rd_data <= '0;
    end
  end
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int          GATE_CYCLES = 50_000_000,
  parameter int          SYNC_STAGES = 2,
  parameter int          CNT_W       = 16,
  parameter int          REG_W       = 16,
  parameter int          ADDR_W      = 8,
  parameter int unsigned REG_OFFSET  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [REG_W-1:0]  rd_data
);
  logic             edge_pulse;
  logic             gate_end;
  logic [CNT_W-1:0] edge_cnt;
  logic [CNT_W-1:0] gate_total;
  logic [CNT_W-1:0] result_q;

  fm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_clk), .rise_pulse(edge_pulse)
  );

  fm_gate #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
    .clk(clk), .rst(rst), .gate_end(gate_end)
  );

  fm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .pulse(edge_pulse), .gate_end(gate_end),
    .cnt_q(edge_cnt), .total(gate_total)
  );

  fm_regport #(.CNT_W(CNT_W), .REG_W(REG_W), .ADDR_W(ADDR_W),
               .REG_OFFSET(REG_OFFSET)) u_reg (
    .clk(clk), .rst(rst), .load(gate_end), .load_val(gate_total),
    .rd_en(rd_en), .rd_addr(rd_addr), .result_q(result_q),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/freq_meter_chk.sv
module freq_meter_chk #(
  parameter int          GATE_CYCLES = 50_000_000,
  parameter int          CNT_W       = 16,
  parameter int          REG_W       = 16,
  parameter int          ADDR_W      = 8,
  parameter int unsigned REG_OFFSET  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              gate_end,
  input logic [CNT_W-1:0]  edge_cnt,
  input logic [CNT_W-1:0]  result_q,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic [REG_W-1:0]  rd_data
);
  localparam int CW = $clog2(GATE_CYCLES) + 1;
  localparam logic [CW-1:0]     LASTC = CW'(GATE_CYCLES - 1);
  localparam logic [CNT_W-1:0]  MAXV  = '1;
  localparam logic [ADDR_W-1:0] OFF   = ADDR_W'(REG_OFFSET);

  logic [CW-1:0] since_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      since_q <= gate_end ? '0 : since_q + 1'b1;
      if (gate_end) seen_q <= 1'b1;
    end
  end

  AST_GATE_SPACING: assert property (@(posedge clk) disable iff (rst)
    gate_end |-> (since_q == LASTC)); // R2
  AST_GATE_DUE: assert property (@(posedge clk) disable iff (rst)
    (since_q == LASTC) |-> gate_end); // R2
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (edge_cnt == MAXV && !gate_end) |=> (edge_cnt == MAXV)); // R4
  AST_ZERO_BEFORE_GATE: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> (result_q == '0)); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !gate_end |=> $stable(result_q)); // R6
  AST_READ_ACK: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R7
  AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != OFF) |=> (rd_data == '0)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && rd_data == '0)); // R9
endmodule

bind freq_meter freq_meter_chk #(
  .GATE_CYCLES(GATE_CYCLES), .CNT_W(CNT_W), .REG_W(REG_W),
  .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) u_chk (
  .clk(clk), .rst(rst), .gate_end(gate_end), .edge_cnt(edge_cnt),
  .result_q(result_q), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/freq_meter_bench.sv
module freq_meter_bench;
  localparam int G     = 240;
  localparam int CNT_W = 6;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_clk = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = 8'h00;
  logic        rd_valid;
  logic [15:0] rd_data;

  freq_meter #(.GATE_CYCLES(G), .CNT_W(CNT_W)) u_freq_meter (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int per_req = 0, hi_req = 0, per_cur = 0, ph = 0;
  int expq[$];
  int last_val = 0;
  bit mon_on = 1'b0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // Pattern generator: period per_cur cycles, high for hi_req of them.
  always @(negedge clk) begin
    if (per_req != per_cur) begin
      per_cur <= per_req;
      ph      <= 0;
      ext_clk <= 1'b0;
    end else if (per_cur == 0) begin
      ext_clk <= 1'b0;
    end else begin
      ext_clk <= (ph < hi_req);
      ph      <= (ph + 1 == per_cur) ? 0 : ph + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Driver: one expected item per gate; first gate after a change is skipped.
  task automatic drive(input int per, input int hi, input int nwin);
    for (int w = 0; w < nwin; w++) begin
      do @(negedge clk); while (!(cyc % G == 0 && cyc > 0));
      if (w == 0) begin
        per_req = per;
        hi_req  = hi;
      end
      if (w == 0) expq.push_back(-1);
      else if (per == 0) expq.push_back(0);
      else expq.push_back(((G / per) > MAXC) ? MAXC : (G / per));
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (cyc == G) check("R5 zero before first gate", int'(rd_data), 0);
      if (cyc >= 2 * G + 1 && cyc % G == 1 && expq.size() > 0) begin
        int e;
        e = expq.pop_front();
        if (e >= 0) begin
          check("R7 valid", int'(rd_valid), 1);
          if (e == MAXC)   check("R4 saturated count", int'(rd_data), e);
          else if (e == 0) check("R10 idle input", int'(rd_data), e);
          else             check("R1 R2 R3 gate count", int'(rd_data), e);
        end
        last_val = int'(rd_data);
      end
      if (cyc >= 2 * G + 1 && cyc % G == G / 2)
        check("R6 held mid-gate", int'(rd_data), last_val);
    end
  end

  initial begin
    #1_500_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R9 reset valid", int'(rd_valid), 0);
    check("R5 reset data", int'(rd_data), 0);
    rd_en   = 1'b1;
    rd_addr = 8'h0A;
    rst     = 1'b0;
    mon_on  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5 early read", int'(rd_data), 0);
    drive(4, 2, 3);
    drive(6, 3, 3);
    drive(2, 1, 3);
    drive(3, 1, 3);
    drive(5, 2, 3);
    drive(0, 0, 3);
    drive(240, 120, 3);
    drive(8, 4, 3);
    while (expq.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    rd_addr = 8'h0C;
    @(negedge clk);
    check("R8 other addr valid", int'(rd_valid), 1);
    check("R8 other addr data", int'(rd_data), 0);
    rd_en = 1'b0;
    rd_addr = 8'h0A;
    @(negedge clk);
    check("R9 idle valid", int'(rd_valid), 0);
    check("R9 idle data", int'(rd_data), 0);
    rd_en = 1'b1;
    @(negedge clk);
    check("R7 read back", int'(rd_data), 30);
    report();
  end
endmodule